// File: doc/BRIEF.md
# Descriptor-Driven CRC Memory Scanner

This block computes a cyclic redundancy checksum over a region of memory without help from a processor. Software writes the address of a small in-memory descriptor, selects one of three polynomials and issues a start command. The block then uses its own read master to fetch the descriptor. The first word gives the region's start address. The second word gives the unit count, the unit width and an interrupt enable.

After the descriptor it issues one read per unit. It folds each byte, halfword or word into a running CRC in the same cycle the data returns, so no buffer is needed. When the last unit is folded in, the block sets a sticky done flag. It also raises its interrupt line if the descriptor asked for one.

The CRC is processed in reflected (least-significant-bit-first) form with no final inversion. A new computation starts from all ones. A configuration bit lets a computation continue from the value left by the previous one, so that scattered regions can be chained into one checksum.

Top module: `crc_scan_engine`

## Requirements
- R1: After reset, mem_req and irq are low, and the status word (selector 3) and the CRC word (selector 4) both read zero.
- R2: A start command (write to selector 2 with data bit 0 set) first reads the word at the descriptor base (selector 0) and then the word at base+4. After that it issues exactly one data read per unit, so a job makes 2+count read handshakes. A start received while busy is ignored.
- R3: Control word fields: bits [15:0] are the unit count, bits [25:24] are the width code (0 = byte, 1 = halfword, 2 and 3 = word) and bit 27 is the interrupt enable. The read address starts at the descriptor's start address and advances by 1, 2 or 4 per unit.
- R4: A byte unit is taken from read-data lane address[1:0] and a halfword from lane address[1]. The unit's bits enter the CRC least significant bit first.
- R5: Configuration bits [1:0] (selector 1) select the polynomial: 0 selects 0x04C11DB7, 1 selects 0x1EDC6F41, and 2 or 3 selects the 16-bit 0x1021. All three are applied in reflected form with no final XOR.
- R6: At start the CRC is set to 0xFFFFFFFF (32-bit) or 0x0000FFFF (16-bit). When configuration bit 2 is set, it instead keeps its previous value, masked to 16 bits in 16-bit mode.
- R7: In 16-bit mode, CRC bits [31:16] read as zero.
- R8: A unit count of zero ends the job after the two descriptor reads, with no data reads. Done is set, and irq is raised if enabled.
- R9: Status bit 0 is busy and bit 1 is done. Done is sticky and is cleared by writing 1 to status bit 1 or by an accepted start. When completion and a clear fall on the same edge, completion wins.
- R10: irq is a registered copy of "done from a job whose interrupt enable was set". It falls when done is cleared.
- R11: Once mem_req is raised, it and mem_addr hold steady until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid the cycle after |
| reg_sel | input | 3 | Register selector: 0 base, 1 config, 2 command, 3 status, 4 CRC |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered register read data |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read byte address |
| mem_ack | input | 1 | Read acknowledge; data is valid in the same cycle |
| mem_rdata | input | 32 | Read data word, little-endian lanes |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The completion of a job and software's write-one-to-clear of the done flag can land on the same clock edge. The bench provokes this by holding the memory acknowledge high, so that a one-unit job finishes a known number of cycles after the start. It then times the clear write onto the edge where done is set. It judges the outcome by reading status and irq afterwards: both must still be set. A clear one cycle later must still work.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH_ADDR,
    ST_FETCH_CTRL,
    ST_STREAM
  } scan_state_e;

  localparam int CTRL_CNT_W   = 16;
  localparam int CTRL_WID_LO  = 24;
  localparam int CTRL_IE_BIT  = 27;

  localparam logic [2:0] SEL_BASE   = 3'd0;
  localparam logic [2:0] SEL_CFG    = 3'd1;
  localparam logic [2:0] SEL_CMD    = 3'd2;
  localparam logic [2:0] SEL_STATUS = 3'd3;
  localparam logic [2:0] SEL_CRC    = 3'd4;

  // reflected polynomial forms
  localparam logic [31:0] RPOLY_ETH  = 32'hEDB88320;
  localparam logic [31:0] RPOLY_CAST = 32'h82F63B78;
  localparam logic [31:0] RPOLY_C16  = 32'h00008408;

  function automatic logic sel_is16(input logic [1:0] sel);
    return sel[1];
  endfunction

  function automatic logic [31:0] sel_poly(input logic [1:0] sel);
    case (sel)
      2'd0:    return RPOLY_ETH;
      2'd1:    return RPOLY_CAST;
      default: return RPOLY_C16;
    endcase
  endfunction

  function automatic logic [5:0] wid_bits(input logic [1:0] wid);
    case (wid)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [2:0] wid_step(input logic [1:0] wid);
    case (wid)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/crc_lane_pick.sv
module crc_lane_pick #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word,
  input  logic [1:0]    lane,
  input  logic [1:0]    wid,
  output logic [DW-1:0] unit
);
  always_comb begin
    case (wid)
      2'd0:    unit = {{(DW-8){1'b0}},  word[{lane, 3'b000} +: 8]};
      2'd1:    unit = {{(DW-16){1'b0}}, word[{lane[1], 4'b0000} +: 16]};
      default: unit = word;
    endcase
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
  parameter int CW = 32
) (
  input  logic [CW-1:0] crc_in,
  input  logic [CW-1:0] data,
  input  logic [5:0]    nbits,
  input  logic [CW-1:0] poly,
  output logic [CW-1:0] crc_out
);
  logic [CW-1:0] c;
  always_comb begin
    c = crc_in;
    for (int i = 0; i < CW; i++) begin
      if (i < int'(nbits))
        c = (c >> 1) ^ ((c[0] ^ data[i]) ? poly : '0);
    end
    crc_out = c;
  end
endmodule

// File: rtl/crc_scan_seq.sv
module crc_scan_seq
  import crc_scan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [1:0]    poly_sel,
  input  logic          keep,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          finish,
  output logic          job_ie,
  output logic          job16,
  output logic [DW-1:0] crc
);
  localparam logic [DW-1:0] ONES32 = '1;
  localparam logic [DW-1:0] ONES16 = DW'(32'h0000FFFF);

  scan_state_e              state;
  logic [AW-1:0]            base_q;
  logic [AW-1:0]            cur_q;
  logic [CTRL_CNT_W-1:0]    cnt_q;
  logic [1:0]               wid_q;
  logic [1:0]               psel_q;
  logic [DW-1:0]            unit;
  logic [DW-1:0]            folded;
  logic                     is16_new;

  assign busy     = (state != ST_IDLE);
  assign is16_new = sel_is16(poly_sel);
  assign job16    = sel_is16(psel_q);

  crc_lane_pick #(.DW(DW)) i_pick (
    .word (mem_rdata),
    .lane (mem_addr[1:0]),
    .wid  (wid_q),
    .unit (unit)
  );

  crc_fold #(.CW(DW)) i_fold (
    .crc_in  (crc),
    .data    (unit),
    .nbits   (wid_bits(wid_q)),
    .poly    (sel_poly(psel_q)),
    .crc_out (folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      base_q   <= '0;
      cur_q    <= '0;
      cnt_q    <= '0;
      wid_q    <= '0;
      psel_q   <= '0;
      job_ie   <= 1'b0;
      crc      <= '0;
      finish   <= 1'b0;
    end else begin
      finish <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_FETCH_ADDR;
            mem_req  <= 1'b1;
            mem_addr <= base;
            base_q   <= base;
            psel_q   <= poly_sel;
            if (keep) crc <= is16_new ? (crc & ONES16) : crc;
            else      crc <= is16_new ? ONES16 : ONES32;
          end
        end
        ST_FETCH_ADDR: begin
          if (mem_ack) begin
            cur_q    <= mem_rdata[AW-1:0];
            mem_addr <= base_q + AW'(4);
            state    <= ST_FETCH_CTRL;
          end
        end
        ST_FETCH_CTRL: begin
          if (mem_ack) begin
            cnt_q  <= mem_rdata[CTRL_CNT_W-1:0];
            wid_q  <= mem_rdata[CTRL_WID_LO +: 2];
            job_ie <= mem_rdata[CTRL_IE_BIT];
            if (mem_rdata[CTRL_CNT_W-1:0] == '0) begin
              state   <= ST_IDLE;
              mem_req <= 1'b0;
              finish  <= 1'b1;
            end else begin
              state    <= ST_STREAM;
              mem_addr <= cur_q;
            end
          end
        end
        default: begin
          if (mem_ack) begin
            crc      <= folded;
            mem_addr <= mem_addr + AW'(wid_step(wid_q));
            cnt_q    <= cnt_q - 1'b1;
            if (cnt_q == CTRL_CNT_W'(1)) begin
              state   <= ST_IDLE;
              mem_req <= 1'b0;
              finish  <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/crc_scan_regs.sv
module crc_scan_regs
  import crc_scan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          finish,
  input  logic          job_ie,
  input  logic [DW-1:0] crc,
  output logic [AW-1:0] base,
  output logic [1:0]    poly_sel,
  output logic          keep,
  output logic          start,
  output logic          done,
  output logic          irq
);
  logic clr_req;
  logic start_ok;

  assign start    = reg_wr && (reg_sel == SEL_CMD) && reg_wdata[0];
  assign start_ok = start && !busy;
  assign clr_req  = (reg_wr && (reg_sel == SEL_STATUS) && reg_wdata[1]) || start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      poly_sel  <= '0;
      keep      <= 1'b0;
      done      <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_BASE) base <= reg_wdata[AW-1:0];
      if (reg_wr && reg_sel == SEL_CFG) begin
        poly_sel <= reg_wdata[1:0];
        keep     <= reg_wdata[2];
      end
      if (finish) begin
        done <= 1'b1;
        if (job_ie) irq <= 1'b1;
      end else if (clr_req) begin
        done <= 1'b0;
        irq  <= 1'b0;
      end
      if (reg_rd) begin
        case (reg_sel)
          SEL_BASE:   reg_rdata <= DW'(base);
          SEL_CFG:    reg_rdata <= DW'({keep, poly_sel});
          SEL_STATUS: reg_rdata <= DW'({done, busy});
          SEL_CRC:    reg_rdata <= crc;
          default:    reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/crc_scan_engine.sv
module crc_scan_engine #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic [AW-1:0] base_w;
  logic [1:0]    psel_w;
  logic          keep_w;
  logic          start_w;
  logic          busy_w;
  logic          finish_w;
  logic          ie_w;
  logic          job16_w;
  logic          done_w;
  logic [DW-1:0] crc_w;

  crc_scan_regs #(.AW(AW), .DW(DW)) i_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy_w), .finish(finish_w), .job_ie(ie_w), .crc(crc_w),
    .base(base_w), .poly_sel(psel_w), .keep(keep_w), .start(start_w),
    .done(done_w), .irq(irq)
  );

  crc_scan_seq #(.AW(AW), .DW(DW)) i_seq (
    .clk(clk), .rst(rst),
    .start(start_w), .base(base_w), .poly_sel(psel_w), .keep(keep_w),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata),
    .busy(busy_w), .finish(finish_w), .job_ie(ie_w), .job16(job16_w),
    .crc(crc_w)
  );
endmodule

// File: rtl/crc_scan_chk.sv
module crc_scan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          irq,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          job16,
  input logic [DW-1:0] crc
);
  // R11: request and address hold until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R2: reads only while a job is running
  a_r2_req_in_job: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R10: interrupt only alongside done
  a_r10_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);

  // R7: upper half of the CRC is zero in 16-bit mode
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    job16 |-> (crc[DW-1:16] == '0));

  // R9: job end is followed by done
  a_r9_done_after_job: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> done);
endmodule

bind crc_scan_engine crc_scan_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst(rst), .busy(busy_w), .done(done_w), .irq(irq),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .job16(job16_w), .crc(crc_w)
);

// File: tb/test_crc_scan_engine.sv
module test_crc_scan_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_ack, irq;
  logic [31:0] mem_addr, mem_rdata;
  logic        ack_en = 1'b1;
  logic        rand_ack = 1'b0;
  logic [31:0] mem [0:255];
  int          nchk = 0, nfail = 0, ack_cnt = 0;
  logic [31:0] a0, a1, prev_crc = 32'hFFFFFFFF;

  always #4 clk = ~clk;

  crc_scan_engine i_crc_scan_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  assign mem_ack   = mem_req && ack_en;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(negedge clk) ack_en <= rand_ack ? (($urandom % 3) != 0) : 1'b1;

  always @(posedge clk) if (mem_req && mem_ack) begin
    if (ack_cnt == 0) a0 = mem_addr;
    if (ack_cnt == 1) a1 = mem_addr;
    ack_cnt = ack_cnt + 1;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R2 act=hung exp=finished");
    report();
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    reg_rd = 1'b1; reg_sel = s;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] rev32(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [31:0] rpoly(input logic [1:0] p);
    if (p == 2'd0) return rev32(32'h04C11DB7);
    if (p == 2'd1) return rev32(32'h1EDC6F41);
    return rev32(32'h00001021) >> 16;
  endfunction

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[9:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] init, input logic [1:0] p,
      input logic [31:0] sa, input int cnt, input logic [1:0] wid);
    logic [31:0] c, pl;
    int nb;
    c = init; pl = rpoly(p);
    nb = (wid == 0) ? 1 : (wid == 1) ? 2 : 4;
    for (int u = 0; u < cnt; u++)
      for (int b = 0; b < nb; b++) begin
        logic [7:0] by;
        by = mbyte(sa + u*nb + b);
        for (int k = 0; k < 8; k++)
          c = (c >> 1) ^ ((c[0] ^ by[k]) ? pl : 32'h0);
      end
    return c;
  endfunction

  task automatic run_job(input logic [1:0] p, input logic [1:0] wid, input int cnt,
      input bit ie, input bit keep, input logic [31:0] sa, input bit extra);
    logic [31:0] d, exp, init;
    bit is16;
    is16 = p[1];
    mem[128] = sa;
    mem[129] = {4'b0, ie, 1'b0, wid, 8'h00, 16'(cnt)};
    mem[130] = 32'hDEADBEEF; mem[131] = 32'hCAFEF00D; mem[132] = 32'h0;
    init = keep ? (is16 ? (prev_crc & 32'hFFFF) : prev_crc) : (is16 ? 32'hFFFF : 32'hFFFFFFFF);
    exp = ref_crc(init, p, sa, cnt, wid);
    wr(3'd0, 32'h200);
    wr(3'd1, {29'b0, keep, p});
    ack_cnt = 0;
    wr(3'd2, 32'h1);
    if (extra) begin
      wr(3'd0, 32'h300);
      wr(3'd2, 32'h1);
    end
    d = 0;
    for (int t = 0; t < 2000 && !d[1]; t++) rd(3'd3, d);
    check(d[1] && !d[0], "R9 done after job", d, 32'h2);
    rd(3'd4, d);
    check(d == exp, $sformatf("R5/R6/R3/R4 crc p=%0d w=%0d n=%0d", p, wid, cnt), d, exp);
    if (is16) check(d[31:16] == 0, "R7 upper zero", d, exp);
    check(ack_cnt == 2 + cnt, "R2/R8 read count", ack_cnt, 2 + cnt);
    check(a0 == 32'h200 && a1 == 32'h204, "R2 descriptor order", a1, 32'h204);
    check(irq == ie, "R10 irq follows enable", irq, ie);
    wr(3'd3, 32'h2);
    @(negedge clk);
    rd(3'd3, d);
    check(d[1] == 0 && irq == 0, "R9 R10 w1c clears", {d[1], irq}, 0);
    prev_crc = exp;
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mem_req == 0 && irq == 0, "R1 reset outputs", {mem_req, irq}, 0);
    rd(3'd3, d); check(d == 0, "R1 status reset", d, 0);
    rd(3'd4, d); check(d == 0, "R1 crc reset", d, 0);

    // directed: each polynomial and width
    run_job(2'd0, 2'd0, 4, 1, 0, 32'h10, 0);
    run_job(2'd1, 2'd1, 3, 0, 0, 32'h22, 0);
    run_job(2'd2, 2'd2, 2, 1, 0, 32'h40, 0);
    run_job(2'd3, 2'd3, 2, 0, 0, 32'h44, 0);  // width code 3 acts as word
    // R8: zero count
    run_job(2'd0, 2'd2, 0, 1, 0, 32'h0, 0);
    // R6: continue from previous value
    run_job(2'd0, 2'd0, 3, 0, 0, 32'h05, 0);
    run_job(2'd0, 2'd1, 2, 0, 1, 32'h30, 0);

    // R9: completion and clear on the same edge; set wins
    mem[128] = 32'h8; mem[129] = {4'b0, 1'b1, 3'b010, 8'h0, 16'd1};
    wr(3'd0, 32'h200); wr(3'd1, 32'h0);
    wr(3'd2, 32'h1);
    repeat (3) @(negedge clk);
    wr(3'd3, 32'h2);
    rd(3'd3, d);
    check(d[1] == 1 && irq == 1, "R9 set wins over clear", {d[1], irq}, 2'b11);
    wr(3'd3, 32'h2);
    rd(3'd3, d);
    check(d[1] == 0 && irq == 0, "R9 later clear works", {d[1], irq}, 0);

    // random stimulus with random acknowledge latency
    rand_ack = 1'b1;
    for (int j = 0; j < 14; j++) begin
      logic [1:0] p, w;
      logic [31:0] sa;
      int n;
      p = 2'($urandom % 4); w = 2'($urandom % 4); n = $urandom % 9;
      sa = ($urandom % 16) * 4;
      if (w == 0) sa = sa + ($urandom % 4);
      if (w == 1) sa = sa + 2 * ($urandom % 2);
      run_job(p, w, n, 1'($urandom % 2), (j > 0) && ($urandom % 2 == 1), sa, 0);
    end
    // R2: start while busy is ignored
    run_job(2'd1, 2'd0, 8, 1, 0, 32'h11, 1);
    report();
  end
endmodule